// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregation Controller

This block gathers 64 synchronous interrupt inputs into two banks of 32 bits and folds them into one registered interrupt request for a single CPU. Each bank keeps a sticky event vector, a software-written enable mask and a copy of the live input levels. A fixed, parameterised set of sources per bank is level-sensitive. Those sources never latch an event, and they assert the request only while their input stays high.

Software uses a 32-bit request bus in a 4 KiB window. A request lasts one cycle and carries a write enable, an address and write data. Read data appears on the cycle after the request. Software can read the event, mask and level vectors of each bank and rewrite the mask. It acknowledges events by writing ones to a clear register. Clear bits that fall on level-sensitive sources are discarded. Input numbers map onto the banks in reverse order: the low 32 inputs feed bank 1 and the high 32 feed bank 0.

Top module: `dual_bank_irq_agg`

## Requirements
- R1: After reset, the event, mask and level vectors of both banks read zero, `cpu_irq` is low and `rdata` is zero.
- R2: Input k drives bit (k & 31) of bank (1 - (k >> 5)). On every clock edge a bank's level vector loads the current state of its inputs, so it is readable at the next read.
- R3: An input that is high at a clock edge and is not level-sensitive sets its event bit. That bit stays set after the input falls, until it is cleared.
- R4: Level-sensitive sources (bank 0: none; bank 1: bits 20 to 28, 0x1FF00000) never set event bits. They drive the request only through the level vector, so they stop requesting as soon as their input falls.
- R5: `cpu_irq` is a register. After each edge it equals the OR over both banks of ((events | (levels & level_sensitive)) & mask), computed from the values that the same edge stores. An input change, a mask write or a clear write therefore shows on `cpu_irq` right after the edge that captures it.
- R6: A write to bank offset 0x8 clears each event bit where the write data holds a 1. Bits of level-sensitive sources are dropped from the data first. If an input is high in the same cycle as a clear of its bit, the event stays set.
- R7: Bank n sits at byte offset 0x10 + 16·n. Within a bank, offset 0x0 reads events, 0x4 reads and writes the mask, 0x8 is the write-only clear register and 0xC reads levels.
- R8: Addresses whose bank index ((addr - 0x10) >> 4, taken modulo the 12-bit window) is 2 or more, and bank offsets other than those in R7, read zero and ignore writes. This includes reads of 0x8.
- R9: `rdata` holds the read value in the cycle after a read request. It is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt sources, already synchronous to clk |
| req | input | 1 | Register bus request, one cycle per access |
| we | input | 1 | Write enable for the request |
| addr | input | 12 | Byte address inside the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions assume that `irq_in`, `req`, `we`, `addr` and `wdata` change only between clock edges and hold steady across each edge. They also assume that no request is open during reset. The stickiness property only applies in cycles without a write, so it depends on the bench leaving `req` low between accesses. The stimulus sets every input one nanosecond after a rising edge and drops `req` after exactly one cycle. It keeps `irq_in` at zero during reset.

// File: rtl/dual_bank_irq_agg.sv
module dual_bank_irq_agg #(
  parameter logic [31:0] LT_BANK0 = 32'h0000_0000,
  parameter logic [31:0] LT_BANK1 = 32'h1FF0_0000,
  parameter int          AW       = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] irq_in,
  input  logic        req,
  input  logic        we,
  input  logic [AW-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        cpu_irq
);
  localparam int IW = AW - 4;
  localparam logic [31:0] LT [2] = '{LT_BANK0, LT_BANK1};

  logic [31:0] ev_q [2];
  logic [31:0] mk_q [2];
  logic [31:0] lv_q [2];
  logic [31:0] ev_n [2];
  logic [31:0] mk_n [2];
  logic [31:0] src  [2];
  logic        pend_n;
  logic [31:0] rd_val;

  wire [AW-1:0] rel = addr - AW'(16);
  wire [IW-1:0] idx = rel[AW-1:4];
  wire [3:0]    off = addr[3:0];
  wire          bsel = idx[0];
  wire          bank_ok = (idx >> 1) == '0;

  assign src[0] = irq_in[63:32];
  assign src[1] = irq_in[31:0];

  always_comb begin
    pend_n = 1'b0;
    for (int b = 0; b < 2; b++) begin
      logic        hit;
      logic [31:0] clr;
      hit     = req && we && bank_ok && (int'(bsel) == b);
      mk_n[b] = (hit && off == 4'h4) ? wdata : mk_q[b];
      clr     = (hit && off == 4'h8) ? (wdata & ~LT[b]) : 32'h0;
      ev_n[b] = (ev_q[b] & ~clr) | (src[b] & ~LT[b]);
      pend_n  = pend_n | (|((ev_n[b] | (src[b] & LT[b])) & mk_n[b]));
    end
  end

  always_comb begin
    rd_val = 32'h0;
    if (bank_ok) begin
      case (off)
        4'h0:    rd_val = ev_q[bsel];
        4'h4:    rd_val = mk_q[bsel];
        4'hC:    rd_val = lv_q[bsel];
        default: rd_val = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        ev_q[b] <= '0;
        mk_q[b] <= '0;
        lv_q[b] <= '0;
      end
      rdata   <= '0;
      cpu_irq <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        ev_q[b] <= ev_n[b];
        mk_q[b] <= mk_n[b];
        lv_q[b] <= src[b];
      end
      rdata   <= (req && !we) ? rd_val : 32'h0;
      cpu_irq <= pend_n;
    end
  end
endmodule

// File: rtl/dual_bank_irq_agg_chk.sv
module dual_bank_irq_agg_chk #(
  parameter logic [31:0] LT0 = 32'h0,
  parameter logic [31:0] LT1 = 32'h1FF0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [63:0] irq_in,
  input logic [31:0] rdata,
  input logic        cpu_irq,
  input logic [31:0] ev0,
  input logic [31:0] ev1,
  input logic [31:0] lv0,
  input logic [31:0] lv1,
  input logic [31:0] mk0,
  input logic [31:0] mk1
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_levels_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (lv1 == $past(irq_in[31:0])) && (lv0 == $past(irq_in[63:32])));

  p_event_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req && we)) |->
      ((ev0 & $past(ev0)) == $past(ev0)) && ((ev1 & $past(ev1)) == $past(ev1)));

  p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> cpu_irq == (|(((ev0 | (lv0 & LT0)) & mk0) | ((ev1 | (lv1 & LT1)) & mk1))));

  p_input_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((ev1 & $past(irq_in[31:0]) & ~LT1) == ($past(irq_in[31:0]) & ~LT1)) &&
                ((ev0 & $past(irq_in[63:32]) & ~LT0) == ($past(irq_in[63:32]) & ~LT0)));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req && !we)) |-> rdata == 32'h0);
endmodule

bind dual_bank_irq_agg dual_bank_irq_agg_chk #(.LT0(LT_BANK0), .LT1(LT_BANK1)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .irq_in(irq_in),
  .rdata(rdata), .cpu_irq(cpu_irq),
  .ev0(ev_q[0]), .ev1(ev_q[1]), .lv0(lv_q[0]), .lv1(lv_q[1]),
  .mk0(mk_q[0]), .mk1(mk_q[1])
);

// File: tb/dual_bank_irq_agg_tb.sv
`timescale 1ns/1ps
module dual_bank_irq_agg_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        req = 0;
  logic        we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  bit rd_prev = 0;

  always #2.5 clk = ~clk;

  dual_bank_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
  );

  always @(negedge clk) begin
    if (rd_prev) begin
      item_t it;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        it = sb.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
    rd_prev = req && !we;
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    cyc();
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    req = 1; we = 0; addr = a;
    cyc();
    req = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (cpu_irq !== e) begin
      errors++;
      $display("FAIL %s: cpu_irq actual %b expected %b", tag, cpu_irq, e);
    end
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk_irq(0, "R1 reset irq");
    checks++;
    if (rdata !== 0) begin
      errors++;
      $display("FAIL R1 reset rdata: actual %h expected 0", rdata);
    end
    rd(12'h010, 0, "R1 ev0");
    rd(12'h014, 0, "R1 mask0");
    rd(12'h02C, 0, "R1 lv1");

    irq_in[3] = 1; cyc(); irq_in[3] = 0; cyc();
    rd(12'h020, 32'h8, "R3 ev1 sticky bit3");
    rd(12'h02C, 0, "R2 lv1 follows low input");
    rd(12'h010, 0, "R2 bank0 untouched by input 3");
    chk_irq(0, "R5 masked event");

    wr(12'h024, 32'h8);
    chk_irq(1, "R5 mask enables event");
    rd(12'h024, 32'h8, "R7 mask1 readback");
    wr(12'h028, 32'h8);
    chk_irq(0, "R6 clear drops irq");
    rd(12'h020, 0, "R6 ev1 cleared");

    irq_in[40] = 1; cyc();
    rd(12'h01C, 32'h100, "R2 lv0 input 40");
    rd(12'h010, 32'h100, "R3 ev0 input 40");
    wr(12'h014, 32'h100);
    chk_irq(1, "R5 bank0 raises irq");
    irq_in[40] = 0; wr(12'h018, 32'h100);
    chk_irq(0, "R5 bank0 cleared");
    wr(12'h014, 0);

    irq_in[25] = 1; cyc();
    rd(12'h020, 0, "R4 no event for level source");
    rd(12'h02C, 32'h0200_0000, "R4 lv1 bit25");
    wr(12'h024, 32'h0200_0000);
    chk_irq(1, "R4 level source irq");
    wr(12'h028, 32'hFFFF_FFFF);
    chk_irq(1, "R6 clear ignores level source");
    irq_in[25] = 0; cyc();
    chk_irq(0, "R4 level source drops");

    irq_in[5] = 1;
    wr(12'h028, 32'h20);
    irq_in[5] = 0; cyc();
    rd(12'h020, 32'h20, "R6 input wins over clear");
    wr(12'h028, 32'h20);
    rd(12'h020, 0, "R6 clear after input low");

    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, 0, "R8 bank2 reads zero");
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 0, "R8 low window reads zero");
    rd(12'h014, 0, "R8 mask0 unchanged");
    rd(12'h024, 32'h0200_0000, "R8 mask1 unchanged");
    irq_in[7] = 1; cyc(); irq_in[7] = 0;
    rd(12'h018, 0, "R8 clear reg reads zero");
    rd(12'h021, 0, "R8 odd offset reads zero");
    rd(12'h020, 32'h80, "R7 ev1 bit7");
    cyc();
    checks++;
    if (rdata !== 0) begin
      errors++;
      $display("FAIL R9 idle rdata: actual %h expected 0", rdata);
    end
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule